// File: doc/BRIEF.md
# Tagged Instruction-Pair Decompressor

This unit sits on the fetch path between an instruction cache that holds compressed code and the processor's fetch port. It reads a continuous bit stream, delivered as 32-bit words, in which each item opens with a 3-bit class tag. One class packs two consecutive instructions that carry no immediate into a single 8-bit index. That index selects a 64-bit entry of a loadable 256-entry table, and the entry expands into two 32-bit instructions. A second class carries a full 32-bit instruction that passes through untouched. Items are bit-aligned, so an item may straddle input words.

Decoding runs in four registered stages: item extraction from the bit buffer, table read, pair formation (splitting the entry), and the output register. Both the input and the output use a valid/ready handshake. The table is specific to one program and is loaded through a write port while the decoder is idle. The immediate and branch classes are not decoded here. Their tags, like any other unknown tag, raise a sticky flag and stop decoding until reset.

Top module: `dcmp_top`

## Requirements
- R1: Tag 3'b010 marks a pair item. The next 8 bits are a table index, and the unit emits bits [63:32] of that table entry first and bits [31:0] second.
- R2: Tag 3'b011 marks a raw item. The next 32 bits are emitted as one instruction, unchanged.
- R3: The stream is read most significant bit first, with input words joined in arrival order. Each item starts at the bit right after the previous item, so items may cross word boundaries.
- R4: Any other tag value sets `unsupported`, which stays set until reset. From then on no further item is taken from the stream, so the only instructions that still leave the unit are those of items taken before the bad tag.
- R5: Instructions leave in stream order, with none dropped or repeated, under any pattern of `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_insn` holds its value.
- R6: A word is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low whenever the bit buffer already holds more than 64 bits. If the output is blocked long enough, `in_ready` falls.
- R7: When `tbl_we` is high, `tbl_data` is written to entry `tbl_addr`. Items decoded later use the new contents. Writes are made only while the pipeline holds no item.
- R8: A synchronous reset empties the bit buffer and all pipeline stages and clears `unsupported`. After reset, `out_valid` is 0 and `in_ready` is 1. Table contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_word | input | 32 | Next 32 stream bits, first bit in bit 31 |
| in_ready | output | 1 | Bit buffer can take a word |
| out_valid | output | 1 | Instruction available |
| out_insn | output | 32 | Decompressed instruction |
| out_ready | input | 1 | Core takes the instruction |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table entry to write |
| tbl_data | input | 64 | Entry contents: first instruction in [63:32], second in [31:0] |
| unsupported | output | 1 | Sticky flag: an unknown class tag was seen |

## Verification
The checker assumes that the table is written only while the pipeline is empty, and it checks this assumption as a property. The bench honours it by loading or rewriting entries only right after a reset, before any stream word is offered. The properties also rely on `out_ready` being driven freely by the consumer. The bench keeps `out_ready` low for long stretches and toggles it at random, so the hold rule and the buffer-full condition are both reached. Streams are padded to a whole word with zero bits, which form an unknown tag. For that reason each scenario begins with a reset, so that a raised flag never leaks into the next scenario.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
    localparam int INSN_W    = 32;
    localparam int TAG_W     = 3;
    localparam int IDX_W     = 8;
    localparam int PAIR_W    = 2 * INSN_W;
    localparam int BUF_W     = 96;
    localparam int CNT_W     = $clog2(BUF_W + 1);
    localparam int PAIR_BITS = TAG_W + IDX_W;
    localparam int RAW_BITS  = TAG_W + INSN_W;
    localparam int TBL_DEPTH = 1 << IDX_W;

    localparam logic [TAG_W-1:0] TAG_PAIR = 3'b010;
    localparam logic [TAG_W-1:0] TAG_RAW  = 3'b011;

    typedef struct packed {
        logic              is_pair;
        logic [IDX_W-1:0]  idx;
        logic [INSN_W-1:0] raw;
    } item_t;
endpackage

// File: rtl/dcmp_bitbuf.sv
// Stage 1: bit-aligned stream buffer and item extraction.
module dcmp_bitbuf
    import dcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_word,
    output logic              in_ready,
    output logic              item_valid,
    output item_t             item,
    input  logic              item_take,
    output logic              take,
    output logic              bad,
    output logic [CNT_W-1:0]  occ
);
    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
        logic             bad;
        logic             iv;
        item_t            item;
    } st_t;

    st_t s_q, s_d;

    logic [TAG_W-1:0] tag;
    logic             have_tag, is_pair, is_raw, slot_free, take_c, rdy;
    logic [CNT_W-1:0] need, shift, mid;

    always_comb begin
        tag       = s_q.bits[BUF_W-1 -: TAG_W];
        have_tag  = s_q.cnt >= CNT_W'(TAG_W);
        is_pair   = (tag == TAG_PAIR);
        is_raw    = (tag == TAG_RAW);
        need      = is_pair ? CNT_W'(PAIR_BITS) : CNT_W'(RAW_BITS);
        slot_free = !s_q.iv || item_take;
        take_c    = have_tag && (is_pair || is_raw) && (s_q.cnt >= need)
                    && slot_free && !s_q.bad;
        shift     = take_c ? need : '0;
        mid       = s_q.cnt - shift;
        rdy       = s_q.cnt <= CNT_W'(BUF_W - INSN_W);

        s_d      = s_q;
        s_d.bad  = s_q.bad | (have_tag && !is_pair && !is_raw);
        s_d.bits = s_q.bits << shift;
        s_d.cnt  = mid;
        if (in_valid && rdy) begin
            s_d.bits = s_d.bits | ({in_word, {(BUF_W-INSN_W){1'b0}}} >> mid);
            s_d.cnt  = mid + CNT_W'(INSN_W);
        end

        if (take_c) begin
            s_d.iv           = 1'b1;
            s_d.item.is_pair = is_pair;
            s_d.item.idx     = s_q.bits[BUF_W-TAG_W-1 -: IDX_W];
            s_d.item.raw     = s_q.bits[BUF_W-TAG_W-1 -: INSN_W];
        end else if (item_take) begin
            s_d.iv = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign in_ready   = rdy;
    assign item_valid = s_q.iv;
    assign item       = s_q.item;
    assign take       = take_c;
    assign bad        = s_q.bad;
    assign occ        = s_q.cnt;
endmodule

// File: rtl/dcmp_pairtab.sv
// Stage 2: pair table storage and registered read.
module dcmp_pairtab
    import dcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [PAIR_W-1:0] wr_data,
    input  logic              in_valid,
    input  item_t             in_item,
    output logic              in_take,
    output logic              out_valid,
    output logic              out_pair,
    output logic [PAIR_W-1:0] out_data,
    input  logic              out_take
);
    typedef struct packed {
        logic              v;
        logic              pair;
        logic [PAIR_W-1:0] data;
    } st_t;

    st_t s_q, s_d;
    logic [PAIR_W-1:0] mem [TBL_DEPTH];
    logic              fire;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        fire = in_valid && (!s_q.v || out_take);
        s_d  = s_q;
        if (fire) begin
            s_d.v    = 1'b1;
            s_d.pair = in_item.is_pair;
            s_d.data = in_item.is_pair ? mem[in_item.idx]
                                       : {in_item.raw, {INSN_W{1'b0}}};
        end else if (out_take) begin
            s_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign in_take   = fire;
    assign out_valid = s_q.v;
    assign out_pair  = s_q.pair;
    assign out_data  = s_q.data;
endmodule

// File: rtl/dcmp_emit.sv
// Stages 3 and 4: pair split and output register.
module dcmp_emit
    import dcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_pair,
    input  logic [PAIR_W-1:0] in_data,
    output logic              in_take,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_insn,
    input  logic              out_ready,
    output logic              busy
);
    typedef struct packed {
        logic              v;
        logic              second;
        logic              pair;
        logic [PAIR_W-1:0] data;
        logic              ov;
        logic [INSN_W-1:0] odata;
    } st_t;

    st_t  s_q, s_d;
    logic d_free, send, last, take_c;

    always_comb begin
        d_free = !s_q.ov || out_ready;
        send   = s_q.v && d_free;
        last   = !s_q.pair || s_q.second;
        take_c = !s_q.v || (send && last);

        s_d = s_q;
        if (send) begin
            s_d.ov    = 1'b1;
            s_d.odata = s_q.second ? s_q.data[INSN_W-1:0]
                                   : s_q.data[PAIR_W-1 -: INSN_W];
            if (last) s_d.v      = 1'b0;
            else      s_d.second = 1'b1;
        end else if (out_ready) begin
            s_d.ov = 1'b0;
        end

        if (in_valid && take_c) begin
            s_d.v      = 1'b1;
            s_d.second = 1'b0;
            s_d.pair   = in_pair;
            s_d.data   = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign in_take   = take_c;
    assign out_valid = s_q.ov;
    assign out_insn  = s_q.odata;
    assign busy      = s_q.v || s_q.ov;
endmodule

// File: rtl/dcmp_top.sv
module dcmp_top
    import dcmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [31:0]         in_word,
    output logic                in_ready,
    output logic                out_valid,
    output logic [31:0]         out_insn,
    input  logic                out_ready,
    input  logic                tbl_we,
    input  logic [7:0]          tbl_addr,
    input  logic [63:0]         tbl_data,
    output logic                unsupported
);
    logic              item_v, item_accept, item_take;
    item_t             item;
    logic [CNT_W-1:0]  buf_occ;
    logic              tab_v, tab_pair, tab_take;
    logic [PAIR_W-1:0] tab_data;
    logic              emit_busy, pipe_busy;

    dcmp_bitbuf u_buf (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .in_ready   (in_ready),
        .item_valid (item_v),
        .item       (item),
        .item_take  (item_accept),
        .take       (item_take),
        .bad        (unsupported),
        .occ        (buf_occ)
    );

    dcmp_pairtab u_tab (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (tbl_we),
        .wr_addr   (tbl_addr),
        .wr_data   (tbl_data),
        .in_valid  (item_v),
        .in_item   (item),
        .in_take   (item_accept),
        .out_valid (tab_v),
        .out_pair  (tab_pair),
        .out_data  (tab_data),
        .out_take  (tab_take)
    );

    dcmp_emit u_emit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (tab_v),
        .in_pair   (tab_pair),
        .in_data   (tab_data),
        .in_take   (tab_take),
        .out_valid (out_valid),
        .out_insn  (out_insn),
        .out_ready (out_ready),
        .busy      (emit_busy)
    );

    assign pipe_busy = item_v || tab_v || emit_busy;
endmodule

// File: rtl/dcmp_chk.sv
module dcmp_chk
    import dcmp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_insn,
    input logic             unsupported,
    input logic             tbl_we,
    input logic             busy,
    input logic             take,
    input logic [CNT_W-1:0] occ
);
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_insn));

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        unsupported |=> unsupported);

    p_halt_r4: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> !take);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(BUF_W));

    p_fill_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> occ >= CNT_W'(INSN_W));

    p_idle_wr_r7: assert property (@(posedge clk) disable iff (rst)
        tbl_we |-> !busy);

    p_reset_r8: assert property (@(posedge clk)
        rst |=> !out_valid && !unsupported && occ == '0);
endmodule

bind dcmp_top dcmp_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_insn    (out_insn),
    .unsupported (unsupported),
    .tbl_we      (tbl_we),
    .busy        (pipe_busy),
    .take        (item_take),
    .occ         (buf_occ)
);

// File: tb/dcmp_top_bench.sv
module dcmp_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_insn;
    logic        out_ready = 1'b0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [63:0] tbl_data = '0;
    logic        unsupported;

    always #5 clk = ~clk;

    dcmp_top u_dcmp_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .out_valid(out_valid), .out_insn(out_insn),
        .out_ready(out_ready), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .unsupported(unsupported)
    );

    int          vectors = 0;
    int          miscompares = 0;
    logic [31:0] expq[$];
    bit          sbits[$];
    logic [31:0] words[$];
    logic [63:0] tbl_m [256];
    int          widx = 0;
    bit          run = 0;
    int          p_in = 100;
    int          p_out = 100;
    string       cur_req = "R1";
    logic [31:0] expect_v;
    int          cyc = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic done();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            done();
        end
    end

    // Reference side: predicts transfers from registered outputs, drives inputs.
    always @(negedge clk) begin
        if (run) begin
            out_ready = ($urandom_range(0, 99) < p_out);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(0, "R5 extra", {32'h0, out_insn}, 64'h0);
                end else begin
                    expect_v = expq.pop_front();
                    chk(out_insn == expect_v, cur_req, {32'h0, out_insn}, {32'h0, expect_v});
                end
            end
            in_valid = (widx < words.size()) && ($urandom_range(0, 99) < p_in);
            in_word  = in_valid ? words[widx] : '0;
            if (in_valid && in_ready) widx++;
        end else begin
            in_valid  = 1'b0;
            out_ready = 1'b0;
        end
    end

    task automatic put_bits(input logic [31:0] v, input int w);
        for (int i = w - 1; i >= 0; i--) sbits.push_back(v[i]);
    endtask

    task automatic add_pair(input int idx);
        put_bits(32'd2, 3);
        put_bits(idx, 8);
        expq.push_back(tbl_m[idx][63:32]);
        expq.push_back(tbl_m[idx][31:0]);
    endtask

    task automatic add_raw(input logic [31:0] x);
        put_bits(32'd3, 3);
        put_bits(x, 32);
        expq.push_back(x);
    endtask

    task automatic pack();
        logic [31:0] w;
        words.delete();
        while (sbits.size() % 32 != 0) sbits.push_back(1'b0);
        for (int k = 0; k < sbits.size() / 32; k++) begin
            for (int b = 0; b < 32; b++) w[31-b] = sbits[k*32+b];
            words.push_back(w);
        end
        sbits.delete();
        widx = 0;
    endtask

    task automatic do_reset();
        run = 0;
        @(negedge clk) rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        expq.delete();
    endtask

    task automatic write_entry(input int a, input logic [63:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a[7:0]; tbl_data = d;
        tbl_m[a] = d;
        @(negedge clk) tbl_we = 1'b0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        cur_req = req;
        run = 1;
        while (expq.size() != 0 && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (n >= 20000) chk(0, {req, " watchdog"}, expq.size(), 0);
        repeat (30) @(posedge clk);
        run = 0;
        @(posedge clk);
    endtask

    initial begin
        // R8: reset state
        do_reset();
        @(negedge clk);
        chk(out_valid == 0, "R8 out_valid", out_valid, 0);
        chk(unsupported == 0, "R8 unsupported", unsupported, 0);
        chk(in_ready == 1, "R8 in_ready", in_ready, 1);

        // R7: load the whole table
        for (int a = 0; a < 256; a++)
            write_entry(a, {32'hC0DE_0000 + a * 32'h101, 32'h1234_0000 ^ (a << 4) ^ 32'h0F});

        // R1, R3: pairs only, full rate, indices at both ends
        do_reset();
        add_pair(0); add_pair(255); add_pair(1);
        for (int i = 0; i < 40; i++) add_pair($urandom_range(0, 255));
        pack();
        p_in = 100; p_out = 100;
        drain("R1");

        // R2, R3: raw only, gaps on input
        do_reset();
        add_raw(32'h0000_0000); add_raw(32'hFFFF_FFFF);
        for (int i = 0; i < 30; i++) add_raw($urandom);
        pack();
        p_in = 60; p_out = 100;
        drain("R2");

        // R3, R5: mixed classes with random stalls on both sides
        do_reset();
        for (int i = 0; i < 200; i++) begin
            if ($urandom_range(0, 1) == 1) add_pair($urandom_range(0, 255));
            else add_raw($urandom);
        end
        pack();
        p_in = 70; p_out = 45;
        drain("R5");

        // R6: output blocked, buffer fills, in_ready falls
        do_reset();
        for (int i = 0; i < 40; i++) add_raw(32'hA500_0000 + i);
        pack();
        p_in = 100; p_out = 0;
        cur_req = "R6";
        run = 1;
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 0, "R6 in_ready", in_ready, 0);
        chk(out_valid == 1, "R6 out_valid", out_valid, 1);
        chk(out_insn == expq[0], "R6 held", out_insn, expq[0]);
        p_out = 100;
        drain("R6");

        // R4: unknown tag halts decoding
        do_reset();
        add_pair(7); add_raw(32'hDEAD_BEEF);
        put_bits(32'd5, 3);
        sbits.push_back(1'b0);
        put_bits(32'd2, 3); put_bits(32'd9, 8);
        put_bits(32'd3, 3); put_bits(32'h1111_2222, 32);
        pack();
        p_in = 100; p_out = 70;
        drain("R4");
        chk(unsupported == 1, "R4 flag", unsupported, 1);

        // R8: reset clears the flag; R7: rewrite entries and use them
        do_reset();
        @(negedge clk);
        chk(unsupported == 0, "R8 flag cleared", unsupported, 0);
        write_entry(5, 64'h0102_0304_0506_0708);
        write_entry(255, 64'hFEDC_BA98_7654_3210);
        add_pair(5); add_raw(32'h7777_0001); add_pair(255); add_pair(0);
        pack();
        p_in = 100; p_out = 100;
        drain("R7");

        done();
    end
endmodule